// File: doc/BRIEF.md
# Switchable Lower Bank Program ROM Mapper

This block sits between a CPU with a 16-bit address bus and a 128 KB program ROM. The CPU sees the ROM through a 32 KB window in the top half of its address space. That window is split into two 16 KB halves. The upper half always shows the final 16 KB of the ROM. The lower half shows whichever 16 KB bank the CPU last chose.

The CPU chooses a bank by writing a byte anywhere in the window. The low nibble of the byte is captured into a bank register on the clock edge. Only its three low bits take part in the ROM address. Reads in the window drive the ROM chip select. The 17-bit ROM address is formed from a 3-bit bank field above the 14-bit offset. The address and chip select are combinational functions of the current bus inputs and the registered bank. A write in the window never drives the ROM chip select, so the ROM never drives the data bus against the CPU.

Top module: `switch_bank_mapper`

## Requirements
- R1: While `rst` is high at a rising edge, the bank register is cleared to 0. A read at `$8000 + n` (n < `$4000`) after reset produces `rom_addr = n`.
- R2: A cycle with `cpu_addr[15] = 1` and `cpu_rw = 0` (write) loads `cpu_data[3:0]` into the bank register at the rising edge. The values of `cpu_addr[14:0]` do not matter. The new bank affects `rom_addr` from the next cycle on.
- R3: A write with `cpu_addr[15] = 0` leaves the bank register unchanged. This is seen on the next lower-half read.
- R4: When `cpu_addr[14] = 0`, `rom_addr[16:14]` equals bank register bits 2:0.
- R5: When `cpu_addr[14] = 1`, `rom_addr[16:14]` is `3'b111`, whatever the bank register holds.
- R6: `rom_sel` is 1 exactly when `cpu_addr[15] = 1` and `cpu_rw = 1` (read). It is 0 on every write and for every address below `$8000`.
- R7: `rom_addr[13:0]` always equals `cpu_addr[13:0]`.
- R8: Reads and cycles outside the window leave the bank register as it is. A loaded bank stays in force until the next write in the window.
- R9: `cpu_data[7:4]` are ignored. `cpu_data[3]` is captured but does not reach `rom_addr`. So a write of `8'h9A` selects bank 2, and a write of `8'h08` selects bank 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; every cycle is one CPU access |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address bus |
| cpu_data | input | 8 | CPU write data bus |
| cpu_rw | input | 1 | Access direction: 1 = read, 0 = write |
| rom_addr | output | 17 | Program ROM byte address |
| rom_sel | output | 1 | ROM chip select, asserted on window reads |

## Verification
The assertions assume that every clock cycle is one valid CPU access with settled address, data and direction. They also assume that reset is held for at least one edge before the first access. The bench changes inputs only at falling edges and holds each access for a whole cycle. It raises reset from time zero and walks through writes inside and outside the window, reads in both halves and data with the high bits set. The reference model tracks the bank as a plain integer and is compared with the outputs on every cycle.

// File: rtl/mapper_pkg.sv
package mapper_pkg;

    typedef enum logic {
        DIR_WRITE = 1'b0,
        DIR_READ  = 1'b1
    } bus_dir_e;

    localparam int CPU_ADDR_W = 16;
    localparam int CPU_DATA_W = 8;

endpackage

// File: rtl/access_decode.sv
module access_decode
    import mapper_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic win_hit,
    input  logic rw,
    output logic bank_wr,
    output logic rom_rd
);

    bus_dir_e dir;

    always_comb begin
        dir     = bus_dir_e'(rw);
        bank_wr = 1'b0;
        rom_rd  = 1'b0;
        if (win_hit) begin
            unique case (dir)
                DIR_WRITE: bank_wr = 1'b1;
                DIR_READ:  rom_rd  = 1'b1;
                default:   rom_rd  = 1'b0;
            endcase
        end
    end

    // R6: the ROM is never selected and written in the same cycle
    p_sel_not_on_write_r6: assert property (@(posedge clk) disable iff (rst)
        !(bank_wr && rom_rd));

    // R6: a write never selects the ROM
    p_write_no_select_r6: assert property (@(posedge clk) disable iff (rst)
        (rw == 1'b0) |-> !rom_rd);

endmodule

// File: rtl/bank_latch.sv
module bank_latch #(
    parameter int DATA_W = 8,
    parameter int BANK_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] din,
    output logic [BANK_W-1:0] bank_q
);

    logic unused_hi_data;

    generate
        if (DATA_W > BANK_W) begin : g_drop_hi
            assign unused_hi_data = ^din[DATA_W-1:BANK_W];
        end else begin : g_no_hi
            assign unused_hi_data = 1'b0;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            bank_q <= '0;
        end else if (load) begin
            bank_q <= din[BANK_W-1:0];
        end
    end

    // R2: a window write loads the low data bits
    p_load_value_r2: assert property (@(posedge clk) disable iff (rst)
        load |=> (bank_q == $past(din[BANK_W-1:0])));

    // R8: without a load the register holds
    p_hold_value_r8: assert property (@(posedge clk) disable iff (rst)
        (!load && !$past(rst)) |=> $stable(bank_q));

endmodule

// File: rtl/rom_addr_mux.sv
module rom_addr_mux #(
    parameter int OFF_W  = 14,
    parameter int SEL_W  = 3,
    parameter int BANK_W = 4
) (
    input  logic                   upper_half,
    input  logic [OFF_W-1:0]       offset,
    input  logic [BANK_W-1:0]      bank,
    output logic [SEL_W+OFF_W-1:0] rom_addr
);

    localparam logic [SEL_W-1:0] LAST_BANK = '1;

    logic [SEL_W-1:0] bank_sel;
    logic             unused_bank_hi;

    generate
        if (BANK_W > SEL_W) begin : g_trim
            assign unused_bank_hi = ^bank[BANK_W-1:SEL_W];
            assign bank_sel       = bank[SEL_W-1:0];
        end else begin : g_pad
            assign unused_bank_hi = 1'b0;
            assign bank_sel       = SEL_W'(bank);
        end
    endgenerate

    always_comb begin
        rom_addr = {upper_half ? LAST_BANK : bank_sel, offset};
    end

endmodule

// File: rtl/switch_bank_mapper.sv
module switch_bank_mapper #(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 8,
    parameter int BANK_W   = 4,
    parameter int ROM_AW   = 17
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_data,
    input  logic              cpu_rw,
    output logic [ROM_AW-1:0] rom_addr,
    output logic              rom_sel
);

    localparam int OFF_W = ADDR_W - 2;
    localparam int SEL_W = ROM_AW - OFF_W;

    logic              bank_wr;
    logic [BANK_W-1:0] bank_q;

    access_decode u_decode (
        .clk     (clk),
        .rst     (rst),
        .win_hit (cpu_addr[ADDR_W-1]),
        .rw      (cpu_rw),
        .bank_wr (bank_wr),
        .rom_rd  (rom_sel)
    );

    bank_latch #(
        .DATA_W (DATA_W),
        .BANK_W (BANK_W)
    ) u_bank (
        .clk    (clk),
        .rst    (rst),
        .load   (bank_wr),
        .din    (cpu_data),
        .bank_q (bank_q)
    );

    rom_addr_mux #(
        .OFF_W  (OFF_W),
        .SEL_W  (SEL_W),
        .BANK_W (BANK_W)
    ) u_mux (
        .upper_half (cpu_addr[ADDR_W-2]),
        .offset     (cpu_addr[OFF_W-1:0]),
        .bank       (bank_q),
        .rom_addr   (rom_addr)
    );

    // R5: upper half is pinned to the last bank
    p_upper_fixed_r5: assert property (@(posedge clk) disable iff (rst)
        cpu_addr[ADDR_W-2] |-> (rom_addr[ROM_AW-1:OFF_W] == {SEL_W{1'b1}}));

    // R4: lower half follows the registered bank
    p_lower_bank_r4: assert property (@(posedge clk) disable iff (rst)
        !cpu_addr[ADDR_W-2] |-> (rom_addr[ROM_AW-1:OFF_W] == bank_q[SEL_W-1:0]));

    // R1: reset leaves bank zero behind
    p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (bank_q == '0));

endmodule

// File: tb/switch_bank_mapper_test.sv
module switch_bank_mapper_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cpu_addr = 16'h0000;
    logic [7:0]  cpu_data = 8'h00;
    logic        cpu_rw = 1'b1;
    logic [16:0] rom_addr;
    logic        rom_sel;

    int checks = 0;
    int errors = 0;
    int bank_m = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    switch_bank_mapper uut (
        .clk      (clk),
        .rst      (rst),
        .cpu_addr (cpu_addr),
        .cpu_data (cpu_data),
        .cpu_rw   (cpu_rw),
        .rom_addr (rom_addr),
        .rom_sel  (rom_sel)
    );

    // Reference model: bank value updated at each edge
    always @(posedge clk) begin
        if (rst) bank_m <= 0;
        else if (cpu_addr[15] && !cpu_rw) bank_m <= int'(cpu_data) % 16;
    end

    task automatic compare(input string req);
        int exp_addr;
        int exp_sel;
        exp_sel  = (cpu_addr[15] && cpu_rw) ? 1 : 0;
        exp_addr = (cpu_addr[14] ? 7 : (bank_m % 8)) * 16384 + int'(cpu_addr[13:0]);
        checks++;
        if (int'(rom_addr) != exp_addr || int'(rom_sel) != exp_sel) begin
            errors++;
            $display("FAIL %s: addr=%0h sel=%0d actual rom_addr=%0h rom_sel=%0d expected rom_addr=%0h rom_sel=%0d",
                     req, cpu_addr, cpu_rw, rom_addr, rom_sel, exp_addr, exp_sel);
        end
    endtask

    task automatic access(input logic [15:0] a, input logic [7:0] d,
                          input logic rw, input string req);
        @(negedge clk);
        cpu_addr = a;
        cpu_data = d;
        cpu_rw   = rw;
        #5;
        compare(req);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: bank zero after reset
        access(16'h8123, 8'h00, 1'b1, "R1");
        access(16'h8000, 8'h00, 1'b1, "R1 R7");
        // R5 upper half fixed
        access(16'hC456, 8'h00, 1'b1, "R5");
        access(16'hFFFF, 8'h00, 1'b1, "R5 R7");
        // R2 write loads bank, R6 no select on write
        access(16'h8000, 8'h05, 1'b0, "R2 R6");
        access(16'h8abc, 8'h00, 1'b1, "R2 R4");
        access(16'hFFFF, 8'h03, 1'b0, "R2 R6");
        access(16'hA000, 8'h00, 1'b1, "R4");
        access(16'hE000, 8'h00, 1'b1, "R5");
        // R3 write outside window
        access(16'h7FFF, 8'h06, 1'b0, "R3 R6");
        access(16'h0100, 8'h00, 1'b1, "R6");
        access(16'h9001, 8'h00, 1'b1, "R3");
        // R8 reads do not disturb
        for (int i = 0; i < 8; i++)
            access(16'(16'h8000 + i * 16'h0811), 8'hFF, 1'b1, "R8");
        // R9 high data ignored
        access(16'hC000, 8'h9A, 1'b0, "R9 R2");
        access(16'h8777, 8'h00, 1'b1, "R9");
        access(16'hBFFF, 8'h08, 1'b0, "R9");
        access(16'h8777, 8'h00, 1'b1, "R9");
        // sweep all banks
        for (int b = 0; b < 16; b++) begin
            access(16'(16'h8000 + b * 16'h0400), 8'(b), 1'b0, "R2");
            access(16'(16'h8000 + b * 16'h0101), 8'h00, 1'b1, "R4 R7");
            access(16'(16'hC000 + b * 16'h0101), 8'h00, 1'b1, "R5");
        end
        // R1 reset again
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        access(16'h8042, 8'h00, 1'b1, "R1");
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #4000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule